// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement State for a 4-Way Cache

This block holds the replacement state of every set of a 4-way set-associative cache and names the way to evict. Each set owns three bits arranged as a binary tree whose leaves are the four ways. The root bit picks one of two way pairs, {0,1} or {2,3}. One leaf bit per pair then picks a way inside that pair.

Whenever the cache reports an access to a way, whether a hit or a fill, the block rewrites the bits on that way's path so that they point away from it. A bit value of 0 points to the left child (pair {0,1}, way 0 or way 2) and 1 points to the right child. Separately, and with no clock latency, the block walks the tree of a looked-up set and returns the victim way as a 2-bit binary number. Tag storage, data arrays and hit detection live outside the block.

Top module: `plru4_state`

## Requirements
- R1: After reset every set's three tree bits are 0, so the victim of every set is way 0.
- R2: The victim walk works as follows. If the root bit is 0, the victim is way 0 when the {0,1} leaf bit is 0, or way 1 when it is 1. If the root bit is 1, the victim is way 2 when the {2,3} leaf bit is 0, or way 3 when it is 1.
- R3: An access to way 0 or 1 sets the root bit of that set to 1. An access to way 2 or 3 sets it to 0.
- R4: An access sets the leaf bit of the accessed pair to point at the sibling. Way 0 gives 1, way 1 gives 0, way 2 gives 1 and way 3 gives 0.
- R5: An access leaves the leaf bit of the other pair unchanged.
- R6: Only the addressed set changes, and only when `upd_valid` is 1. With `upd_valid` at 0, `upd_set` and `upd_way` have no effect.
- R7: `victim_way` follows `look_set` in the same cycle. When a lookup and an update address the same set in one cycle, the lookup returns the state from before the update.
- R8: In the cycle after an access to way w of a set, the victim of that set is not w. After accesses to ways 0, 1, 2 and 3 in that order, the victim is way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Access strobe for a hit or a fill |
| upd_set | input | 4 | Set index of the access |
| upd_way | input | 2 | Way accessed, binary 0..3 |
| look_set | input | 4 | Set index to find a victim for |
| victim_way | output | 2 | Way to replace in `look_set`, binary 0..3 |

## Verification
The update and the lookup can land on the same set in one cycle. The bench provokes this in a directed case and also throughout a long random run, where the lookup index often equals the update index. In each such cycle the bench compares `victim_way`, sampled before the clock edge, with the victim computed from its own model of the pre-update tree. The model is advanced only after that edge. This shows that the new tree bits become visible one cycle later and never in the same cycle.

// File: rtl/plru4_state.sv
module plru4_state #(
  parameter int SETS = 16,
  localparam int IW = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_valid,
  input  logic [IW-1:0] upd_set,
  input  logic [1:0]    upd_way,
  input  logic [IW-1:0] look_set,
  output logic [1:0]    victim_way
);

  // bit0 = root, bit1 = {0,1} leaf, bit2 = {2,3} leaf
  logic [2:0] tree_q [SETS];
  logic [2:0] cur_bits, nxt_bits, look_bits;

  function automatic logic [1:0] walk(input logic [2:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  assign cur_bits  = tree_q[upd_set];
  assign look_bits = tree_q[look_set];
  assign victim_way = walk(look_bits);

  always_comb begin
    nxt_bits    = cur_bits;
    nxt_bits[0] = ~upd_way[1];
    if (upd_way[1]) nxt_bits[2] = ~upd_way[0];
    else            nxt_bits[1] = ~upd_way[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) tree_q[i] <= 3'b000;
    end else if (upd_valid) begin
      tree_q[upd_set] <= nxt_bits;
    end
  end

  // R8
  away_from_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> walk(tree_q[$past(upd_set)]) != $past(upd_way));

  // R5
  other_pair_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (tree_q[$past(upd_set)][1] == $past(cur_bits[1]) || !$past(upd_way[1]))
               && (tree_q[$past(upd_set)][2] == $past(cur_bits[2]) ||  $past(upd_way[1])));

  for (genvar s = 0; s < SETS; s++) begin : g_set_chk
    // R6
    idle_set_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_valid && upd_set == IW'(s)) |=> $stable(tree_q[s]));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> tree_q[s] == 3'b000);
  end

endmodule

// File: tb/plru4_state_tb.sv
module plru4_state_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_valid = 1'b0;
  logic [3:0] upd_set = '0;
  logic [1:0] upd_way = '0;
  logic [3:0] look_set = '0;
  logic [1:0] victim_way;

  int vectors = 0;
  int miscompares = 0;
  logic [2:0] model [SETS];

  always #(CLK_PERIOD/2) clk = ~clk;

  plru4_state u_dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_set(upd_set),
    .upd_way(upd_way), .look_set(look_set), .victim_way(victim_way)
  );

  // R2 from the requirement text
  function automatic logic [1:0] ref_victim(input logic [2:0] t);
    if (t[0] == 1'b0) return (t[1] == 1'b0) ? 2'd0 : 2'd1;
    else              return (t[2] == 1'b0) ? 2'd2 : 2'd3;
  endfunction

  // R3, R4, R5 from the requirement text
  function automatic logic [2:0] ref_update(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n = t;
    case (w)
      2'd0: begin n[0] = 1'b1; n[1] = 1'b1; end
      2'd1: begin n[0] = 1'b1; n[1] = 1'b0; end
      2'd2: begin n[0] = 1'b0; n[2] = 1'b1; end
      default: begin n[0] = 1'b0; n[2] = 1'b0; end
    endcase
    return n;
  endfunction

  task automatic check(input logic [1:0] exp, input string req);
    vectors++;
    if (victim_way !== exp) begin
      miscompares++;
      $display("FAIL %s: victim_way=%0d expected %0d (look_set=%0d)", req, victim_way, exp, look_set);
    end
  endtask

  // one cycle: drive at negedge, check pre-update victim, advance model after edge
  task automatic step(input logic v, input logic [3:0] s, input logic [1:0] w,
                      input logic [3:0] ls, input string req);
    @(negedge clk);
    upd_valid = v; upd_set = s; upd_way = w; look_set = ls;
    #1;
    check(ref_victim(model[ls]), req);
    @(posedge clk);
    if (v) model[s] = ref_update(model[s], w);
  endtask

  task automatic look(input logic [3:0] ls, input logic [1:0] exp, input string req);
    @(negedge clk);
    upd_valid = 1'b0; look_set = ls;
    #1;
    check(exp, req);
    if (ref_victim(model[ls]) !== exp) $display("model disagrees with directed value for %s", req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < SETS; i++) model[i] = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every set reports way 0 after reset
    for (int i = 0; i < SETS; i++) look(4'(i), 2'd0, "R1");

    // R8 / R3 / R4: ways 0,1,2,3 in order on set 5
    step(1'b1, 4'd5, 2'd0, 4'd5, "R7");
    look(4'd5, 2'd2, "R3 after way0");
    step(1'b1, 4'd5, 2'd1, 4'd5, "R7");
    look(4'd5, 2'd2, "R3 after way1");
    step(1'b1, 4'd5, 2'd2, 4'd5, "R7");
    look(4'd5, 2'd0, "R4 after way2");
    step(1'b1, 4'd5, 2'd3, 4'd5, "R7");
    look(4'd5, 2'd0, "R8 order 0123");

    // R5: pair {2,3} leaf survives an access to way 0
    step(1'b1, 4'd7, 2'd2, 4'd0, "R2");
    step(1'b1, 4'd7, 2'd0, 4'd0, "R2");
    look(4'd7, 2'd3, "R5");

    // R6: strobe low and another set updated leave set 7 alone
    step(1'b0, 4'd7, 2'd1, 4'd7, "R6");
    look(4'd7, 2'd3, "R6 strobe low");
    step(1'b1, 4'd9, 2'd3, 4'd7, "R6");
    look(4'd7, 2'd3, "R6 other set");
    look(4'd9, 2'd0, "R4 way3");

    // R7: same-set lookup and update show old state; new state next cycle
    step(1'b1, 4'd7, 2'd3, 4'd7, "R7 same cycle");
    look(4'd7, 2'd1, "R7 next cycle");

    // random mix with frequent set collisions
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] s = 4'($urandom_range(0, 3));
      logic [3:0] ls = ($urandom_range(0, 1) == 0) ? s : 4'($urandom_range(0, 3));
      step(($urandom_range(0, 3) != 0), s, 2'($urandom_range(0, 3)), ls, "R2/R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule